// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block connects an internal single-outstanding bus master to an external asynchronous static RAM of 64K words by 16 bits. A request carries a read/write flag, a word address, write data and a two-bit byte enable. The controller turns it into a sequenced memory cycle: a setup cycle, a counted access phase, and a hold cycle. It then returns read data with a one-cycle completion pulse.

On the memory side the controller drives two chip selects of opposite polarity, an output enable, a write enable, a strobe for each byte lane, and the address. The data bus is split into an output word, a per-lane drive enable and an input word, so a pad ring or bench can build the tristate bus. Byte enable bit 0 maps to the low strobe and data bits 7:0. Bit 1 maps to the high strobe and bits 15:8. This allows writes and reads of either byte alone.

The access-phase length is a cycle-count parameter. It is chosen so that the phase covers the memory's access time at the system clock; a 35 ns part at 100 MHz needs at least 4 cycles. A request with no byte enabled completes at once without any write or read phase.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, the outputs are in their idle state: memCs1N=1, memCs2=0, memWeN=1, memOeN=1, memLbN=1, memUbN=1, memDqOe=2'b00 and rspDone=0.
- R2: For every access, memCs1N is low and memCs2 is high, together, for every cycle from the setup cycle through the hold cycle. That is ACCESS_CYC+2 cycles, or 1 cycle when the byte enable is 2'b00.
- R3: During an access, memLbN is low exactly when reqBe[0] was 1, and it governs data bits 7:0. memUbN is low exactly when reqBe[1] was 1, and it governs bits 15:8. memDqOe[0] and memDqOe[1] are the drive enables for those same two lanes.
- R4: A write with a nonzero byte enable holds memWeN low for exactly ACCESS_CYC cycles and keeps memOeN high throughout. memDqOut is driven only on enabled lanes, so only the enabled bytes of the memory word change.
- R5: A read with a nonzero byte enable holds memOeN low for exactly ACCESS_CYC cycles, keeps memWeN high, and never raises memDqOe. rspRdata takes memDqIn at the end of the last access cycle on the enabled lanes and reads 0 on the disabled lanes.
- R6: memAddr and the byte strobes are presented one cycle before memWeN falls and kept one cycle after memWeN rises, with the chip selected in both of those cycles.
- R7: rspDone is high for exactly one cycle. For a nonzero byte enable, it is high in the cycle that starts ACCESS_CYC+1 rising edges after the edge that accepts the request.
- R8: A request with byte enable 2'b00 raises rspDone in the cycle right after the accepting edge. It never lowers memWeN or memOeN, leaves the memory contents unchanged, and leaves rspRdata unchanged.
- R9: A request is accepted only when no access is in progress. Changes to reqValid, reqAddr or reqWdata while an access is in progress have no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present (taken only when idle) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Word address |
| reqWdata | input | 16 | Write data |
| reqBe | input | 2 | Byte enable, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rspRdata | output | 16 | Captured read data |
| rspDone | output | 1 | One-cycle completion pulse |
| memCs1N | output | 1 | Active-low chip select |
| memCs2 | output | 1 | Active-high chip select |
| memOeN | output | 1 | Active-low output enable |
| memWeN | output | 1 | Active-low write enable |
| memLbN | output | 1 | Active-low low-byte strobe |
| memUbN | output | 1 | Active-low high-byte strobe |
| memAddr | output | 16 | Memory word address |
| memDqOut | output | 16 | Data driven toward the memory |
| memDqOe | output | 2 | Per-lane drive enable for memDqOut |
| memDqIn | input | 16 | Data returned from the memory bus |

## Verification
A wrong sequencer state shows at the memory pins within the same cycle. Examples are a write enable low period of the wrong length, output enable overlapping a lane drive, or a chip select dropping early. The completion pulse then arrives on the wrong edge, which the scoreboard's latency check catches on that transaction. A wrong latched byte enable or address is visible only later: the read-back of a partially written word returns the wrong byte. The read-backs are placed right after each partial write so that such an error shows up within one transaction.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACCESS,
    ST_HOLD
  } ctrlState_e;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;      // latch the host request
    logic sel;       // chip selected, lanes strobed per byte enable
    logic weOn;      // write enable active
    logic oeOn;      // output enable active
    logic busDrive;  // controller owns the data bus
    logic capture;   // take read data this edge
  } laneCtrl_t;

endpackage

// File: rtl/sram_lane_fsm.sv
module sram_lane_fsm
  import sram_lane_pkg::*;
#(
  parameter int ACCESS_CYC = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqBeZero,
  input  logic      curWrite,
  output laneCtrl_t ctrl,
  output logic      done
);

  localparam int CW = $clog2(ACCESS_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(ACCESS_CYC - 1);

  ctrlState_e state;
  logic [CW-1:0] waitCnt;
  logic lastWait;

  assign lastWait = (waitCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (reqValid) state <= reqBeZero ? ST_HOLD : ST_SETUP;
        end
        ST_SETUP: begin
          state   <= ST_ACCESS;
          waitCnt <= '0;
        end
        ST_ACCESS: begin
          if (lastWait) state <= ST_HOLD;
          else waitCnt <= waitCnt + 1'b1;
        end
        ST_HOLD: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl          = '0;
    ctrl.load     = (state == ST_IDLE) && reqValid;
    ctrl.sel      = (state != ST_IDLE);
    ctrl.weOn     = (state == ST_ACCESS) && curWrite;
    ctrl.oeOn     = (state == ST_ACCESS) && !curWrite;
    ctrl.busDrive = (state != ST_IDLE) && curWrite;
    ctrl.capture  = (state == ST_ACCESS) && lastWait && !curWrite;
  end

  assign done = (state == ST_HOLD);

endmodule

// File: rtl/sram_lane_dp.sv
module sram_lane_dp
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  laneCtrl_t           ctrl,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqBe,
  output logic                curWrite,
  output logic [DATA_W-1:0]   rspRdata,
  output logic                memCs1N,
  output logic                memCs2,
  output logic                memOeN,
  output logic                memWeN,
  output logic [DATA_W/8-1:0] memLaneN,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memDqOut,
  output logic [DATA_W/8-1:0] memDqOe,
  input  logic [DATA_W-1:0]   memDqIn
);

  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  beQ;
  logic              writeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      beQ    <= '0;
      writeQ <= 1'b0;
    end else if (ctrl.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      beQ    <= reqBe;
      writeQ <= reqWrite;
    end
  end

  assign curWrite = writeQ;
  assign memAddr  = addrQ;
  assign memDqOut = wdataQ;
  assign memCs1N  = ~ctrl.sel;
  assign memCs2   = ctrl.sel;
  assign memWeN   = ~ctrl.weOn;
  assign memOeN   = ~ctrl.oeOn;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign memLaneN[l] = ~(ctrl.sel & beQ[l]);
    assign memDqOe[l]  = ctrl.busDrive & beQ[l];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rspRdata[l*8 +: 8] <= '0;
      end else if (ctrl.capture) begin
        rspRdata[l*8 +: 8] <= beQ[l] ? memDqIn[l*8 +: 8] : 8'h00;
      end
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int ACCESS_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqWdata,
  input  logic [1:0]        reqBe,
  output logic [15:0]       rspRdata,
  output logic              rspDone,
  output logic              memCs1N,
  output logic              memCs2,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memLbN,
  output logic              memUbN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memDqOut,
  output logic [1:0]        memDqOe,
  input  logic [15:0]       memDqIn
);

  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;

  laneCtrl_t        ctrl;
  logic             curWrite;
  logic [LANES-1:0] laneN;

  sram_lane_fsm #(.ACCESS_CYC(ACCESS_CYC)) fsm_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqBeZero(~|reqBe),
    .curWrite (curWrite),
    .ctrl     (ctrl),
    .done     (rspDone)
  );

  sram_lane_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .reqWrite(reqWrite),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqBe   (reqBe),
    .curWrite(curWrite),
    .rspRdata(rspRdata),
    .memCs1N (memCs1N),
    .memCs2  (memCs2),
    .memOeN  (memOeN),
    .memWeN  (memWeN),
    .memLaneN(laneN),
    .memAddr (memAddr),
    .memDqOut(memDqOut),
    .memDqOe (memDqOe),
    .memDqIn (memDqIn)
  );

  assign memLbN = laneN[0];
  assign memUbN = laneN[1];

endmodule

// File: rtl/sram_lane_chk.sv
module sram_lane_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              memCs1N,
  input logic              memCs2,
  input logic              memOeN,
  input logic              memWeN,
  input logic              memLbN,
  input logic              memUbN,
  input logic [ADDR_W-1:0] memAddr,
  input logic [1:0]        memDqOe,
  input logic              rspDone
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    memCs1N |-> (memLbN && memUbN && memWeN && memOeN && memDqOe == 2'b00 && !rspDone));

  p_cs_pair_r2: assert property (@(posedge clk) disable iff (!rstN)
    memCs1N == !memCs2);

  p_lane_drive_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memDqOe[0] |-> !memLbN) and (memDqOe[1] |-> !memUbN));

  p_oe_off_in_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN);

  p_no_contention_r5: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memDqOe == 2'b00));

  p_we_setup_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> ($past(!memCs1N) && $stable(memAddr) && $stable({memLbN, memUbN})));

  p_we_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (!memCs1N && $stable(memAddr) && $stable({memLbN, memUbN})));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

endmodule

bind sram_lane_ctrl sram_lane_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .memCs1N(memCs1N),
  .memCs2 (memCs2),
  .memOeN (memOeN),
  .memWeN (memWeN),
  .memLbN (memLbN),
  .memUbN (memUbN),
  .memAddr(memAddr),
  .memDqOe(memDqOe),
  .rspDone(rspDone)
);

// File: tb/sram_lane_ctrl_tb_top.sv
module sram_lane_ctrl_tb_top;

  localparam int ACC = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqBe = '0;
  logic [15:0] rspRdata;
  logic        rspDone;
  logic        memCs1N, memCs2, memOeN, memWeN, memLbN, memUbN;
  logic [15:0] memAddr, memDqOut;
  logic [1:0]  memDqOe;
  logic [15:0] memDqIn = 16'hA5A5;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int doneCnt = 0;
  bit finished = 0;

  sram_lane_ctrl #(.ADDR_W(16), .ACCESS_CYC(ACC)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .rspRdata(rspRdata), .rspDone(rspDone),
    .memCs1N(memCs1N), .memCs2(memCs2), .memOeN(memOeN), .memWeN(memWeN),
    .memLbN(memLbN), .memUbN(memUbN), .memAddr(memAddr),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory model
  logic [15:0] bmem [int];
  logic [15:0] shadow [int];

  function automatic logic [15:0] rdWord(input logic [15:0] a);
    return bmem.exists(int'(a)) ? bmem[int'(a)] : 16'h0000;
  endfunction

  always @(negedge clk) begin
    logic selNow;
    logic [15:0] w;
    logic [1:0] laneOn;
    selNow = !memCs1N && memCs2;
    laneOn = {!memUbN, !memLbN};
    w = rdWord(memAddr);
    if (selNow && !memWeN) begin
      for (int l = 0; l < 2; l++) begin
        if (laneOn[l]) begin
          if (memDqOe[l]) w[l*8 +: 8] = memDqOut[l*8 +: 8];
          else check(1'b0, "R4 write lane not driven", {30'd0, memDqOe}, {30'd0, laneOn});
        end
      end
      bmem[int'(memAddr)] = w;
    end
    if (selNow && memWeN && !memOeN) begin
      for (int l = 0; l < 2; l++)
        memDqIn[l*8 +: 8] <= laneOn[l] ? w[l*8 +: 8] : 8'hA5;
    end else begin
      memDqIn <= 16'hA5A5;
    end
  end

  // Scoreboard
  typedef struct {
    bit          isWrite;
    logic [1:0]  be;
    logic [15:0] expRd;
    int          acceptCyc;
  } sbItem_t;
  sbItem_t sbQ[$];

  int weCnt = 0, oeCnt = 0, selCnt = 0;
  logic [1:0] laneSeen = '0;
  logic prevWeN = 1'b1, prevSel = 1'b0, prevLbN = 1'b1, prevUbN = 1'b1;
  logic [15:0] prevAddr = '0;

  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (memCs1N) begin
        if (!(memLbN && memUbN && memWeN && memOeN && memDqOe == 2'b00 && !rspDone && !memCs2))
          check(1'b0, "R1 idle outputs", {26'd0, memCs2, memLbN, memUbN, memWeN, memOeN, rspDone},
                6'b011110);
      end else begin
        selCnt++;
        laneSeen |= {!memUbN, !memLbN};
        if (!memCs2) check(1'b0, "R2 cs pair", {31'd0, memCs2}, 1);
      end
      if (!memWeN) weCnt++;
      if (!memOeN) oeCnt++;
      if (!memOeN && memDqOe != 2'b00) check(1'b0, "R5 bus contention", {30'd0, memDqOe}, 0);
      if (prevWeN && !memWeN)
        check(prevSel && prevAddr == memAddr && prevLbN == memLbN && prevUbN == memUbN,
              "R6 setup before WE", {16'd0, prevAddr}, {16'd0, memAddr});
      if (!prevWeN && memWeN)
        check(!memCs1N && prevAddr == memAddr && prevLbN == memLbN && prevUbN == memUbN,
              "R6 hold after WE", {16'd0, memAddr}, {16'd0, prevAddr});
      if (rspDone) begin
        sbItem_t it;
        int lat, expLat, expWe, expOe, expSel;
        if (sbQ.size() == 0) begin
          check(1'b0, "R7 unexpected done", 1, 0);
        end else begin
          it = sbQ.pop_front();
          lat = cyc - it.acceptCyc;
          expLat = (it.be == 2'b00) ? 0 : ACC + 1;
          expWe = (it.isWrite && it.be != 0) ? ACC : 0;
          expOe = (!it.isWrite && it.be != 0) ? ACC : 0;
          expSel = (it.be == 2'b00) ? 1 : ACC + 2;
          check(lat == expLat, (it.be == 0) ? "R8 latency" : "R7 latency", lat, expLat);
          check(weCnt == expWe, (it.be == 0) ? "R8 WE count" : "R4 WE low cycles", weCnt, expWe);
          check(oeCnt == expOe, (it.be == 0) ? "R8 OE count" : "R5 OE low cycles", oeCnt, expOe);
          check(selCnt == expSel, "R2 select cycles", selCnt, expSel);
          check(laneSeen == it.be, "R3 lane strobes", {30'd0, laneSeen}, {30'd0, it.be});
          if (!it.isWrite)
            check(rspRdata == it.expRd, (it.be == 0) ? "R8 rdata kept" : "R5 read data",
                  {16'd0, rspRdata}, {16'd0, it.expRd});
        end
        weCnt = 0; oeCnt = 0; selCnt = 0; laneSeen = '0;
        doneCnt++;
      end
    end
    prevWeN = memWeN; prevSel = !memCs1N; prevAddr = memAddr;
    prevLbN = memLbN; prevUbN = memUbN;
  end

  logic [15:0] lastRd = 16'h0000;

  task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] be, input bit mutate = 1'b0);
    sbItem_t it;
    logic [15:0] w;
    int startDone;
    w = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    it.isWrite = wr;
    it.be = be;
    it.expRd = 16'h0000;
    if (wr) begin
      for (int l = 0; l < 2; l++) if (be[l]) w[l*8 +: 8] = d[l*8 +: 8];
      shadow[int'(a)] = w;
    end else if (be == 2'b00) begin
      it.expRd = lastRd;
    end else begin
      for (int l = 0; l < 2; l++) if (be[l]) it.expRd[l*8 +: 8] = w[l*8 +: 8];
      lastRd = it.expRd;
    end
    @(negedge clk);
    startDone = doneCnt;
    it.acceptCyc = cyc + 1;
    sbQ.push_back(it);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = be;
    @(negedge clk);
    if (mutate) begin
      reqAddr = a + 16'd1; reqWdata = ~d; reqWrite = ~wr;
    end else begin
      reqValid = 1'b0;
    end
    wait (doneCnt != startDone);
    reqValid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(memCs1N && !memCs2 && memWeN && memOeN && memLbN && memUbN && memDqOe == 0 && !rspDone,
          "R1 reset outputs", {26'd0, memCs1N, memCs2, memWeN, memOeN, memLbN, memUbN}, 6'b101111);
    rstN = 1'b1;
    @(negedge clk);
    check(memCs1N && memWeN && memOeN && rspRdata == 16'h0, "R1 after reset", {16'd0, rspRdata}, 0);

    access(1, 16'h0010, 16'h1234, 2'b11);
    access(0, 16'h0010, 16'h0000, 2'b11);        // R5 full read
    access(1, 16'h0010, 16'hABCD, 2'b01);        // R3 low lane only
    access(0, 16'h0010, 16'h0000, 2'b11);
    access(1, 16'h0010, 16'h7799, 2'b10);        // R3 high lane only
    access(0, 16'h0010, 16'h0000, 2'b01);        // R5 disabled lane reads 0
    access(0, 16'h0010, 16'h0000, 2'b10);
    access(1, 16'h0010, 16'hFFFF, 2'b00);        // R8 no-lane write
    access(0, 16'h0010, 16'h0000, 2'b11);        // R8 memory unchanged
    access(0, 16'h0010, 16'h0000, 2'b00);        // R8 rdata unchanged
    access(1, 16'h0000, 16'h0F0F, 2'b11);
    access(1, 16'hFFFF, 16'hF00D, 2'b11);
    access(0, 16'h0000, 16'h0000, 2'b11);
    access(0, 16'hFFFF, 16'h0000, 2'b11);
    access(1, 16'h0020, 16'h5555, 2'b11, 1'b1);  // R9 inputs change mid-access
    access(0, 16'h0020, 16'h0000, 2'b11);
    access(0, 16'h0021, 16'h0000, 2'b11);
    for (int i = 0; i < 8; i++)
      access(1, 16'h0100 + 16'(i * 37), 16'(16'h3C00 + i * 16'h0111), 2'(i % 3 + 1));
    for (int i = 0; i < 8; i++)
      access(0, 16'h0100 + 16'(i * 37), 16'h0000, 2'b11);

    repeat (3) @(negedge clk);
    check(memCs1N && memWeN && memOeN && memLbN && memUbN, "R1 idle at end",
          {28'd0, memCs1N, memWeN, memOeN, memLbN}, 4'hF);
    check(sbQ.size() == 0, "R7 all requests completed", sbQ.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL R7 watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule